// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide bank of board control ports that sits behind an I/O byte bus. Software reaches it through a single soft-reset port and a window of control ports. The window holds fixed identification bytes for the board, a disk activity light, two NVRAM lock strobes, a four-bit system control field, a cache status byte and a bit that selects the I/O address map type. A separate pair of byte ports serves as plain scratch storage.

Writes take effect at the rising clock edge on which `wrEn` is high. Reads are combinational: `rdData` follows `addr` in the same cycle, so a read presented together with a write returns the value held before the write. Any address that has no readable register returns 0xFF. The reset request, the lock strobes, the light and the map-type bit are driven straight to the rest of the board.

Top module: `sysctl_bank`

## Requirements
- R1: A read of any address without a readable register returns 0xFF. This includes the write-only ports 0x0810, 0x0812 and 0x0814, and also 0x0801 and any address outside the decoded ports.
- R2: A write to 0x0092 sets `resetReq` to bit 0 of the written byte from the next cycle on. A read of 0x0092 returns {7'b0, resetReq}.
- R3: The read-only identity bytes are 0x0800 = 0xEF, 0x0802 = 0xAD, 0x0803 = 0xE0, 0x080C = 0x39 and 0x081D = 0x03. Writes to these ports change nothing.
- R4: A write to 0x081C stores bits 3:0 of the byte. A read of 0x081C returns {4'b0, stored}.
- R5: A write to 0x0850 stores bit 0, which drives `mapType`. A read of 0x0850 returns {7'b0, mapType}.
- R6: A write to 0x0808 stores bit 0, which drives `activityLight`. A read of 0x0808 returns {7'b0, activityLight}.
- R7: Each write to 0x0810 (or 0x0812) drives `lockPulseA` (or `lockPulseB`) high for exactly the following cycle, whatever the data. Back-to-back writes keep the strobe high for one cycle per write.
- R8: A write to 0x0814 has no effect on any output or on any readable value.
- R9: Ports 0x0398 and 0x0399 are independent 8-bit read/write scratch bytes.
- R10: Reset clears every stored bit and both scratch bytes, and deasserts `resetReq` and both lock strobes.
- R11: A read presented in the same cycle as a write to the same port returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte port address |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| resetReq | output | 1 | Soft reset request to the processor |
| lockPulseA | output | 1 | One-cycle strobe toggling NVRAM lock 1 |
| lockPulseB | output | 1 | One-cycle strobe toggling NVRAM lock 2 |
| activityLight | output | 1 | Disk activity light drive |
| mapType | output | 1 | I/O map type select to the address translator |

## Verification
Two functions can meet in one cycle. The first is a combinational read of a port, which sees the old value while a write to that same port is being taken. The second is a lock strobe still high from the previous write while the next lock write arrives. The bench provokes the first by checking `rdData` between the write's setup and its clock edge, both in directed cases and on every random write. It provokes the second by holding `wrEn` on the lock port for two cycles, and expects the strobe high on both following cycles and low on the third. The random mix of writes and reads then catches any decode overlap that would leak one write into another register.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned PORT_W = 16;

  localparam logic [PORT_W-1:0] PORT_SOFTRST = 16'h0092;
  localparam logic [PORT_W-1:0] PORT_CPUCFG  = 16'h0800;
  localparam logic [PORT_W-1:0] PORT_FEAT    = 16'h0802;
  localparam logic [PORT_W-1:0] PORT_MODSTAT = 16'h0803;
  localparam logic [PORT_W-1:0] PORT_LIGHT   = 16'h0808;
  localparam logic [PORT_W-1:0] PORT_EXTFEAT = 16'h080C;
  localparam logic [PORT_W-1:0] PORT_LOCKA   = 16'h0810;
  localparam logic [PORT_W-1:0] PORT_LOCKB   = 16'h0812;
  localparam logic [PORT_W-1:0] PORT_L2INV   = 16'h0814;
  localparam logic [PORT_W-1:0] PORT_SYSCTL  = 16'h081C;
  localparam logic [PORT_W-1:0] PORT_L2STAT  = 16'h081D;
  localparam logic [PORT_W-1:0] PORT_MAPTYPE = 16'h0850;
  localparam logic [PORT_W-1:0] PORT_SCRBASE = 16'h0398;

  localparam int unsigned SCRATCH_N  = 2;
  localparam int unsigned SCR_IDX_W  = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
  localparam int unsigned SYSCTL_W   = 4;

  localparam logic [7:0] ID_CPUCFG  = 8'hEF;
  localparam logic [7:0] ID_FEAT    = 8'hAD;
  localparam logic [7:0] ID_MODSTAT = 8'hE0;
  localparam logic [7:0] ID_EXTFEAT = 8'h39;
  localparam logic [7:0] ID_L2STAT  = 8'h03;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_SOFTRST,
    SEL_CPUCFG,
    SEL_FEAT,
    SEL_MODSTAT,
    SEL_EXTFEAT,
    SEL_LIGHT,
    SEL_SYSCTL,
    SEL_L2STAT,
    SEL_MAPTYPE,
    SEL_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic                 wrSoftRst;
    logic                 wrLight;
    logic                 wrLockA;
    logic                 wrLockB;
    logic                 wrSysCtl;
    logic                 wrMapType;
    logic [SCRATCH_N-1:0] wrScratch;
    rdSel_e               rdSel;
    logic [SCR_IDX_W-1:0] scrIdx;
  } strobes_t;

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output strobes_t          strobes
);

  localparam logic [ADDR_W-1:0] SCR_LO = ADDR_W'(PORT_SCRBASE);
  localparam logic [ADDR_W-1:0] SCR_HI = ADDR_W'(PORT_SCRBASE + SCRATCH_N);

  logic              inScratch;
  logic [ADDR_W-1:0] scrOffset;

  assign inScratch = (addr >= SCR_LO) && (addr < SCR_HI);
  assign scrOffset = addr - SCR_LO;

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = SEL_NONE;
    strobes.scrIdx = SCR_IDX_W'(scrOffset);
    if (inScratch) begin
      strobes.rdSel = SEL_SCRATCH;
      strobes.wrScratch[strobes.scrIdx] = wrEn;
    end else begin
      case (addr)
        ADDR_W'(PORT_SOFTRST): begin
          strobes.rdSel     = SEL_SOFTRST;
          strobes.wrSoftRst = wrEn;
        end
        ADDR_W'(PORT_CPUCFG):  strobes.rdSel = SEL_CPUCFG;
        ADDR_W'(PORT_FEAT):    strobes.rdSel = SEL_FEAT;
        ADDR_W'(PORT_MODSTAT): strobes.rdSel = SEL_MODSTAT;
        ADDR_W'(PORT_EXTFEAT): strobes.rdSel = SEL_EXTFEAT;
        ADDR_W'(PORT_L2STAT):  strobes.rdSel = SEL_L2STAT;
        ADDR_W'(PORT_LIGHT): begin
          strobes.rdSel   = SEL_LIGHT;
          strobes.wrLight = wrEn;
        end
        ADDR_W'(PORT_LOCKA):   strobes.wrLockA = wrEn;
        ADDR_W'(PORT_LOCKB):   strobes.wrLockB = wrEn;
        ADDR_W'(PORT_L2INV):   strobes.rdSel = SEL_NONE;
        ADDR_W'(PORT_SYSCTL): begin
          strobes.rdSel    = SEL_SYSCTL;
          strobes.wrSysCtl = wrEn;
        end
        ADDR_W'(PORT_MAPTYPE): begin
          strobes.rdSel     = SEL_MAPTYPE;
          strobes.wrMapType = wrEn;
        end
        default: strobes.rdSel = SEL_NONE;
      endcase
    end
  end

  // R7: at most one register write strobe per cycle
  always_comb begin
    assert ($countones({strobes.wrSoftRst, strobes.wrLight, strobes.wrLockA,
                        strobes.wrLockB, strobes.wrSysCtl, strobes.wrMapType,
                        strobes.wrScratch}) <= 1)
      else $error("p_one_strobe_r7");
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq,
  output logic              lockPulseA,
  output logic              lockPulseB,
  output logic              activityLight,
  output logic              mapType
);

  logic [SYSCTL_W-1:0] sysCtl;
  logic [DATA_W-1:0]   scratch [SCRATCH_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq      <= 1'b0;
      activityLight <= 1'b0;
      mapType       <= 1'b0;
      sysCtl        <= '0;
      lockPulseA    <= 1'b0;
      lockPulseB    <= 1'b0;
    end else begin
      lockPulseA <= strobes.wrLockA;
      lockPulseB <= strobes.wrLockB;
      if (strobes.wrSoftRst) resetReq      <= wrData[0];
      if (strobes.wrLight)   activityLight <= wrData[0];
      if (strobes.wrMapType) mapType       <= wrData[0];
      if (strobes.wrSysCtl)  sysCtl        <= wrData[SYSCTL_W-1:0];
    end
  end

  for (genvar i = 0; i < SCRATCH_N; i++) begin : g_scratch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    scratch[i] <= '0;
      else if (strobes.wrScratch[i]) scratch[i] <= wrData;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_SOFTRST: rdData = DATA_W'(resetReq);
      SEL_CPUCFG:  rdData = DATA_W'(ID_CPUCFG);
      SEL_FEAT:    rdData = DATA_W'(ID_FEAT);
      SEL_MODSTAT: rdData = DATA_W'(ID_MODSTAT);
      SEL_EXTFEAT: rdData = DATA_W'(ID_EXTFEAT);
      SEL_LIGHT:   rdData = DATA_W'(activityLight);
      SEL_SYSCTL:  rdData = DATA_W'(sysCtl);
      SEL_L2STAT:  rdData = DATA_W'(ID_L2STAT);
      SEL_MAPTYPE: rdData = DATA_W'(mapType);
      SEL_SCRATCH: rdData = scratch[strobes.scrIdx];
      default:     rdData = '1;
    endcase
  end

  p_light_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrLight |=> $stable(activityLight))
    else $error("p_light_hold_r6");

  p_sysctl_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSysCtl |=> $stable(sysCtl))
    else $error("p_sysctl_hold_r4");

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq,
  output logic              lockPulseA,
  output logic              lockPulseB,
  output logic              activityLight,
  output logic              mapType
);

  strobes_t strobes;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  sysctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (wrData),
    .rdData        (rdData),
    .resetReq      (resetReq),
    .lockPulseA    (lockPulseA),
    .lockPulseB    (lockPulseB),
    .activityLight (activityLight),
    .mapType       (mapType)
  );

  p_lock_a_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockPulseA |-> $past(wrEn && addr == ADDR_W'(PORT_LOCKA)))
    else $error("p_lock_a_src_r7");

  p_lock_b_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockPulseB |-> $past(wrEn && addr == ADDR_W'(PORT_LOCKB)))
    else $error("p_lock_b_src_r7");

  p_softrst_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(PORT_SOFTRST)) |=> resetReq == $past(wrData[0]))
    else $error("p_softrst_r2");

  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'(PORT_MAPTYPE)) |=> $stable(mapType))
    else $error("p_map_hold_r5");

  p_cpucfg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(PORT_CPUCFG)) |-> rdData == DATA_W'(ID_CPUCFG))
    else $error("p_cpucfg_r3");

  p_far_unused_r1: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1 -: 4] != '0) |-> rdData == '1)
    else $error("p_far_unused_r1");

endmodule

// File: tb/sysctl_bank_bench.sv
`timescale 1ns/1ps
module sysctl_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        resetReq, lockPulseA, lockPulseB, activityLight, mapType;

  int errors = 0;
  int checks = 0;

  // model state
  logic       mRst, mLight, mMap;
  logic [3:0] mSys;
  logic [7:0] mScr [2];

  always #4 clk = ~clk;

  sysctl_bank u_sysctl_bank (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .resetReq(resetReq), .lockPulseA(lockPulseA),
    .lockPulseB(lockPulseB), .activityLight(activityLight), .mapType(mapType)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [15:0] a);
    case (a)
      16'h0092: return {7'b0, mRst};
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h39;
      16'h081D: return 8'h03;
      16'h0808: return {7'b0, mLight};
      16'h081C: return {4'b0, mSys};
      16'h0850: return {7'b0, mMap};
      16'h0398: return mScr[0];
      16'h0399: return mScr[1];
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic string tagOf(input logic [15:0] a);
    case (a)
      16'h0092: return "R2";
      16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h081D: return "R3";
      16'h081C: return "R4";
      16'h0850: return "R5";
      16'h0808: return "R6";
      16'h0810, 16'h0812: return "R7";
      16'h0814: return "R8";
      16'h0398, 16'h0399: return "R9";
      default:  return "R1";
    endcase
  endfunction

  function automatic void modelWrite(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h0092: mRst   = d[0];
      16'h0808: mLight = d[0];
      16'h081C: mSys   = d[3:0];
      16'h0850: mMap   = d[0];
      16'h0398: mScr[0] = d;
      16'h0399: mScr[1] = d;
      default: ;
    endcase
  endfunction

  task automatic checkOutputs(input logic [15:0] lastWr, input bit wasWr, input string tag);
    chk(resetReq == mRst, {tag, " R2 resetReq"}, resetReq, mRst);
    chk(activityLight == mLight, {tag, " R6 light"}, activityLight, mLight);
    chk(mapType == mMap, {tag, " R5 mapType"}, mapType, mMap);
    chk(lockPulseA == (wasWr && lastWr == 16'h0810), {tag, " R7 lockA"},
        lockPulseA, (wasWr && lastWr == 16'h0810));
    chk(lockPulseB == (wasWr && lastWr == 16'h0812), {tag, " R7 lockB"},
        lockPulseB, (wasWr && lastWr == 16'h0812));
  endtask

  // write one byte; the read of the same port is checked before the edge (R11)
  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    #1;
    chk(rdData == expRead(a), {tagOf(a), " R11 old value during write"}, rdData, expRead(a));
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
    checkOutputs(a, 1'b1, tagOf(a));
  endtask

  task automatic doRead(input logic [15:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdData == expRead(a), {tagOf(a), " read"}, rdData, expRead(a));
  endtask

  localparam logic [15:0] PICK [16] = '{
    16'h0092, 16'h0800, 16'h0801, 16'h0802, 16'h0803, 16'h0808, 16'h080C, 16'h0810,
    16'h0812, 16'h0814, 16'h081C, 16'h081D, 16'h0850, 16'h0398, 16'h0399, 16'h0851
  };

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20240611);
    mRst = 0; mLight = 0; mMap = 0; mSys = 0; mScr[0] = 0; mScr[1] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(resetReq == 0 && lockPulseA == 0 && lockPulseB == 0, "R10 outputs in reset",
        {resetReq, lockPulseA, lockPulseB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    foreach (PICK[i]) doRead(PICK[i]);
    checkOutputs(16'h0000, 1'b0, "R10");

    // directed corners
    doWrite(16'h0092, 8'h01);
    doRead(16'h0092);
    doWrite(16'h0092, 8'hFE);
    doWrite(16'h081C, 8'hFA);
    doRead(16'h081C);
    doWrite(16'h0800, 8'h00);
    doRead(16'h0800);
    doWrite(16'h0850, 8'hFF);
    doRead(16'h0850);
    doWrite(16'h0808, 8'h03);
    doRead(16'h0808);
    doWrite(16'h0398, 8'hA5);
    doWrite(16'h0399, 8'h5A);
    doRead(16'h0398);
    doRead(16'h0399);
    doWrite(16'h0814, 8'hFF);
    doRead(16'h0814);
    doRead(16'hF123);
    doRead(16'h0851);

    // R7 back-to-back lock writes: two cycles high, then low
    @(negedge clk);
    addr = 16'h0810; wrData = 8'h00; wrEn = 1'b1;
    @(negedge clk);
    chk(lockPulseA == 1'b1, "R7 first back-to-back pulse", lockPulseA, 1);
    @(negedge clk);
    wrEn = 1'b0;
    chk(lockPulseA == 1'b1, "R7 second back-to-back pulse", lockPulseA, 1);
    @(negedge clk);
    chk(lockPulseA == 1'b0 && lockPulseB == 1'b0, "R7 pulse ends", lockPulseA, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = ($urandom % 8 == 0) ? 16'($urandom) : PICK[$urandom % 16];
      d = 8'($urandom);
      if ($urandom % 2) doWrite(a, d);
      else begin
        doRead(a);
        checkOutputs(16'h0000, 1'b0, "R8 idle");
      end
    end

    // R10 reset mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    mRst = 0; mLight = 0; mMap = 0; mSys = 0; mScr[0] = 0; mScr[1] = 0;
    @(negedge clk);
    rstN = 1'b1;
    doRead(16'h0398);
    doRead(16'h081C);
    checkOutputs(16'h0000, 1'b0, "R10 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule